// File: doc/BRIEF.md
# Bus Strobe Sampling Synchronizer

This block sits at the edge of a chip that is reached from an external microcontroller bus. The bus has an active-low chip select, an active-low read strobe and one active-low write strobe per byte lane. None of these lines is related to the local clock. Each line passes through a two-flop synchronizer. A per-line sampling filter then cleans it up under one of two rules, chosen by a 2-bit mode input:

- **Two-point rule:** a new level is accepted only when two consecutive samples agree.
- **One-point rule:** the first sample is taken as it is.

The filtered levels are decoded into access events. Each read or write produces exactly one single-cycle start pulse in the local clock domain. Each write pulse carries the active byte lanes. The bus address is latched on the cycle each event fires.

The outputs are plain pulses and registers. There is no valid/ready handshake and no back-pressure. A consumer must act on a start pulse in the cycle it is high. The latched lanes and address stay valid until the next event of the same kind (lanes) or of either kind (address).

The address input must be held stable from the start of a strobe until the event fires. If the read strobe and any write strobe are active together, the access is a read.

Top module: `bus_strobe_sync`

## Requirements
- R1: After reset, `rd_start_o`, `wr_start_o`, `wr_lanes_o` and `addr_o` are all zero, and no event fires while all strobes stay high.
- R2: A read is recognised when `cs_n_i` and `rd_n_i` are both low after filtering; it produces a one-cycle `rd_start_o` pulse.
- R3: A write is recognised when `cs_n_i` is low and at least one bit of `wr_n_i` is low; it produces a one-cycle `wr_start_o` pulse. In that cycle `wr_lanes_o` bit i is 1 exactly when `wr_n_i` bit i was low.
- R4: When the read strobe and any write strobe are active together, only `rd_start_o` fires; `rd_start_o` and `wr_start_o` are never high in the same cycle.
- R5: One access gives one event. No further event fires until every strobe has been seen inactive again. This holds even if a write strobe joins a read that is already running, and releasing the strobes fires nothing.
- R6: With `smode_i` = 2'b10 (two-point), a level is accepted only after two consecutive samples agree. A strobe low for less than one clock is rejected. A stable strobe's event appears on the 5th rising edge after the strobe falls.
- R7: With `smode_i` = 2'b11 (one-point), a single sample decides the level. A strobe pulse shorter than a clock that is caught by one edge gives an event. A stable strobe's event appears on the 4th rising edge after the strobe falls.
- R8: `smode_i` values 2'b00 and 2'b01 behave exactly like two-point mode (rejection and 5-edge latency).
- R9: `addr_o` takes `addr_i` on the cycle an event fires and holds it otherwise; `wr_lanes_o` changes only when a write event fires.
- R10: While `cs_n_i` is high, low read or write strobes cause no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smode_i | input | 2 | Sampling rule: 2'b11 one-point, all other values two-point |
| cs_n_i | input | 1 | Asynchronous chip select, active low |
| rd_n_i | input | 1 | Asynchronous read strobe, active low |
| wr_n_i | input | LANES | Asynchronous per-lane write strobes, active low |
| addr_i | input | ADDR_W | Bus address, stable while strobes are active |
| rd_start_o | output | 1 | One-cycle read start pulse |
| wr_start_o | output | 1 | One-cycle write start pulse |
| wr_lanes_o | output | LANES | Byte lanes of the last write, 1 = active |
| addr_o | output | ADDR_W | Address latched at the last event |

## Verification
A strobe change is picked up by the first rising edge after it. The event then follows on the 4th edge in one-point mode and the 5th edge in two-point mode: two synchronizer flops, the second sample, the filter register and the event register. The bench drives every input on a falling edge. From there it counts rising edges and samples each output 1 ns after every edge. It records the edge index of the first pulse and the total pulse count in an 8-edge window, and compares both with the expected latency and with a count of one. Sub-clock glitches are placed to straddle a single rising edge, so the synchronizer sees them for exactly one cycle. Two-point rejection and one-point acceptance are therefore deterministic.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    SMODE_TWO_A = 2'b00,
    SMODE_TWO_B = 2'b01,
    SMODE_TWO   = 2'b10,
    SMODE_ONE   = 2'b11
  } smode_e;

  function automatic logic one_point(input logic [1:0] m);
    return m == SMODE_ONE;
  endfunction
endpackage

// File: rtl/bss_sync2.sv
module bss_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bss_point_filter.sv
module bss_point_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic one_pt_i,
  input  logic pt1_i,
  output logic level_o
);
  logic pt2_q, level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt2_q   <= 1'b1;
      level_q <= 1'b1;
    end else begin
      pt2_q <= pt1_i;
      if (one_pt_i)
        level_q <= pt1_i;
      else if (pt1_i == pt2_q)
        level_q <= pt1_i;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/bss_access_decode.sv
module bss_access_decode #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic [LANES-1:0]  wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_start_o,
  output logic              wr_start_o,
  output logic [LANES-1:0]  wr_lanes_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic rd_act, wr_req, wr_act, busy_q;
  logic fire_rd, fire_wr;
  logic rd_q, wr_q;
  logic [LANES-1:0]  lanes_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    rd_act  = !cs_n_i && !rd_n_i;
    wr_req  = !cs_n_i && (wr_n_i != '1);
    wr_act  = wr_req && !rd_act;
    fire_rd = rd_act && !busy_q;
    fire_wr = wr_act && !busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      lanes_q <= '0;
      addr_q  <= '0;
    end else begin
      busy_q <= rd_act || wr_req;
      rd_q   <= fire_rd;
      wr_q   <= fire_wr;
      if (fire_wr)
        lanes_q <= ~wr_n_i;
      if (fire_rd || fire_wr)
        addr_q <= addr_i;
    end
  end

  assign rd_start_o = rd_q;
  assign wr_start_o = wr_q;
  assign wr_lanes_o = lanes_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/bus_strobe_sync.sv
module bus_strobe_sync #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        smode_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic [LANES-1:0]  wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_start_o,
  output logic              wr_start_o,
  output logic [LANES-1:0]  wr_lanes_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int NSIG   = LANES + 2;
  localparam int IDX_CS = NSIG - 1;
  localparam int IDX_RD = NSIG - 2;

  logic [NSIG-1:0] raw_vec, pt1_vec, lvl_vec;
  logic            one_pt;

  assign raw_vec = {cs_n_i, rd_n_i, wr_n_i};
  assign one_pt  = bss_pkg::one_point(smode_i);

  bss_sync2 #(.W(NSIG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_vec),
    .q_o   (pt1_vec)
  );

  for (genvar i = 0; i < NSIG; i++) begin : g_filt
    bss_point_filter u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .one_pt_i (one_pt),
      .pt1_i    (pt1_vec[i]),
      .level_o  (lvl_vec[i])
    );
  end

  bss_access_decode #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (lvl_vec[IDX_CS]),
    .rd_n_i     (lvl_vec[IDX_RD]),
    .wr_n_i     (lvl_vec[LANES-1:0]),
    .addr_i     (addr_i),
    .rd_start_o (rd_start_o),
    .wr_start_o (wr_start_o),
    .wr_lanes_o (wr_lanes_o),
    .addr_o     (addr_o)
  );
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_start,
  input logic              wr_start,
  input logic [LANES-1:0]  wr_lanes,
  input logic [ADDR_W-1:0] addr
);
  p_no_dual_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start && wr_start));

  p_rd_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  p_wr_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  p_wr_has_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (wr_lanes != '0));

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start || wr_start) |-> $stable(addr));

  p_lanes_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_start |-> $stable(wr_lanes));
endmodule

bind bus_strobe_sync bss_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_start (rd_start_o),
  .wr_start (wr_start_o),
  .wr_lanes (wr_lanes_o),
  .addr     (addr_o)
);

// File: tb/bus_strobe_sync_bench.sv
`timescale 1ns/1ps
module bus_strobe_sync_bench;
  localparam int LANES  = 4;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        smode = 2'b10;
  logic              csn = 1'b1;
  logic              rdn = 1'b1;
  logic [LANES-1:0]  wrn = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic              rd_start, wr_start;
  logic [LANES-1:0]  lanes;
  logic [ADDR_W-1:0] addr_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_strobe_sync #(.LANES(LANES), .ADDR_W(ADDR_W)) u_bus_strobe_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .smode_i    (smode),
    .cs_n_i     (csn),
    .rd_n_i     (rdn),
    .wr_n_i     (wrn),
    .addr_i     (addr),
    .rd_start_o (rd_start),
    .wr_start_o (wr_start),
    .wr_lanes_o (lanes),
    .addr_o     (addr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called right after a falling edge; counts the next 8 rising edges.
  task automatic watch(input int exp_cyc, input bit exp_rd, input string tag);
    int first = 0;
    int n = 0;
    bit kind_rd = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); #1;
      if (rd_start || wr_start) begin
        n++;
        if (first == 0) begin
          first = c;
          kind_rd = rd_start;
        end
      end
    end
    chk(first == exp_cyc, {tag, " first event edge"}, first, exp_cyc);
    chk(n == (exp_cyc != 0 ? 1 : 0), {tag, " event count"}, n, exp_cyc != 0 ? 1 : 0);
    if (exp_cyc != 0)
      chk(kind_rd == exp_rd, {tag, " event kind rd"}, kind_rd, exp_rd);
  endtask

  task automatic release_all(input string tag);
    @(negedge clk);
    csn = 1'b1; rdn = 1'b1; wrn = '1;
    watch(0, 1'b0, tag);
  endtask

  task automatic t_reset();
    chk(!rd_start && !wr_start, "R1 pulses low after reset", rd_start + wr_start, 0);
    chk(lanes == '0, "R1 lanes zero", lanes, 0);
    chk(addr_o == '0, "R1 addr zero", addr_o, 0);
    @(negedge clk);
    watch(0, 1'b0, "R1 idle");
  endtask

  task automatic t_read_two();
    @(negedge clk);
    smode = 2'b10; addr = 16'h1234; csn = 1'b0; rdn = 1'b0;
    watch(5, 1'b1, "R2 R6 read two-point");
    chk(addr_o == 16'h1234, "R9 read addr", addr_o, 16'h1234);
    release_all("R5 read release");
  endtask

  task automatic t_read_one();
    @(negedge clk);
    smode = 2'b11; addr = 16'h00A5; csn = 1'b0; rdn = 1'b0;
    watch(4, 1'b1, "R7 read one-point");
    chk(addr_o == 16'h00A5, "R9 addr one-point", addr_o, 16'h00A5);
    release_all("R7 release");
    smode = 2'b10;
  endtask

  task automatic t_write();
    @(negedge clk);
    smode = 2'b10; addr = 16'hBEEF; csn = 1'b0; wrn = 4'b1010;
    watch(5, 1'b0, "R3 write");
    chk(lanes == 4'b0101, "R3 lanes", lanes, 4'b0101);
    chk(addr_o == 16'hBEEF, "R9 write addr", addr_o, 16'hBEEF);
    release_all("R3 release");
  endtask

  task automatic t_both();
    @(negedge clk);
    addr = 16'h0F0F; csn = 1'b0; rdn = 1'b0; wrn = 4'b0111;
    watch(5, 1'b1, "R4 read wins");
    chk(lanes == 4'b0101, "R4 lanes untouched", lanes, 4'b0101);
    release_all("R4 release");
  endtask

  task automatic t_hold_join();
    @(negedge clk);
    addr = 16'h2222; csn = 1'b0; rdn = 1'b0;
    watch(5, 1'b1, "R5 held read");
    @(negedge clk);
    wrn = 4'b1110;
    watch(0, 1'b0, "R5 write joins running read");
    chk(lanes == 4'b0101, "R5 lanes unchanged", lanes, 4'b0101);
    release_all("R5 release");
  endtask

  task automatic t_cs_high();
    @(negedge clk);
    addr = 16'h7777; rdn = 1'b0; wrn = 4'b0000;
    watch(0, 1'b0, "R10 cs high ignored");
    chk(addr_o == 16'h2222, "R10 addr unchanged", addr_o, 16'h2222);
    release_all("R10 release");
  endtask

  task automatic t_glitch(input logic [1:0] m, input int exp_cyc, input string tag);
    @(negedge clk);
    smode = m; addr = 16'h3C3C; csn = 1'b0;
    watch(0, 1'b0, {tag, " cs settle"});
    @(negedge clk);
    fork
      watch(exp_cyc, 1'b1, tag);
      begin #1 rdn = 1'b0; #2 rdn = 1'b1; end
    join
    release_all({tag, " release"});
  endtask

  task automatic t_mode01_read();
    @(negedge clk);
    smode = 2'b01; addr = 16'h4444; csn = 1'b0; rdn = 1'b0;
    watch(5, 1'b1, "R8 mode 01 read");
    release_all("R8 release");
    smode = 2'b10;
  endtask

  task automatic t_addr_hold();
    @(negedge clk);
    addr = 16'hDEAD;
    watch(0, 1'b0, "R9 addr change idle");
    chk(addr_o == 16'h4444, "R9 addr held", addr_o, 16'h4444);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_read_two();
    t_read_one();
    t_write();
    t_both();
    t_hold_join();
    t_cs_high();
    t_glitch(2'b10, 0, "R6 glitch two-point rejected");
    t_glitch(2'b11, 4, "R7 glitch one-point accepted");
    t_glitch(2'b00, 0, "R8 glitch mode 00 rejected");
    t_mode01_read();
    t_addr_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule